// File: doc/BRIEF.md
# Synchronous Shared Address/Data Burst Port Slave

This block is the slave end of a synchronous parallel port on which one 16-bit bus carries both the address and the data. Host and slave run on one clock and launch and sample on the same rising edge. The host opens a cycle by holding chip enable and the address strobe low together, which latches the low bits of the bus as an address. It then holds output enable low for a fixed-length read burst, or write enable low for a fixed-length write burst. The block paces every burst with a RDY line. A latency setting picks whether data and RDY follow the enable by one cycle or by two.

Read beats come from an internal buffer. That buffer is filled through a valid/ready input stream: `src_ready` is high whenever a word can be accepted, and a word transfers on any edge where both `src_valid` and `src_ready` are high. Write beats go into a second buffer, which is drained through a valid/ready output stream. `snk_valid` stays high while the buffer holds data, and `snk_data` holds the oldest word until an edge where `snk_ready` is high. Back-pressure acts only at burst boundaries. A burst does not start until its buffer can supply or absorb a whole burst, so once RDY rises it stays high to the end of the burst.

The pad driver is outside this block: `dq_o` is placed on the bus when `dq_oe` is high, and `dq_i` is the value received from the bus.

Top module: `admux_burst_slave`

## Requirements
- R1: On an edge where `adv_n` and `ce_n` are both low, `addr` takes `dq_i[ADDR_W-1:0]`. On every other edge `addr` keeps its value.
- R2: Let L be the latency (2 by default, 1 in short mode). If read data is available, RDY goes high and `dq_o` shows beat 0 with `dq_oe` high L cycles after the edge that first samples `oe_n` low together with `ce_n` low.
- R3: Read beats follow one per cycle, in buffer order, for BURST beats. RDY falls one cycle after the last beat is presented. The last beat stays on `dq_o` until `oe_n` rises, and `dq_oe` falls one cycle after the edge that samples `oe_n` high. `dq_oe` is never high during a write.
- R4: RDY rises L cycles after the edge that first samples `we_n` low with `ce_n` low. A beat is captured from `dq_i` on each edge where RDY is high, up to BURST beats, and leaves on the sink stream in capture order.
- R5: After the edge that captures the last write beat, RDY stays high for two more sampling edges and is seen low at the third.
- R6: `lat_short` = 1 selects L = 1 and `lat_short` = 0 selects L = 2. The setting is taken only on edges where `ce_n` is high, and changing it while `ce_n` is low has no effect.
- R7: A read burst starts only when the read buffer holds at least BURST words. A write burst starts only when the write buffer has at least BURST free entries. Until then RDY stays low, and once a burst has started RDY does not fall before its last beat.
- R8: If `oe_n` rises before a read burst ends, RDY and `dq_oe` fall after the next edge and the unread beats of that burst are discarded. The next read burst begins with the word that follows the aborted burst.
- R9: If `we_n` rises before a write burst ends, RDY falls after the next edge and no further beats of that burst are captured.
- R10: `src_ready` is low exactly when the read buffer is full. The sink stream delivers every captured word once and in order, and holds it under back-pressure.
- R11: After reset, RDY, `dq_oe` and `snk_valid` are low and `addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the host |
| rst_n | input | 1 | Active-low asynchronous reset |
| lat_short | input | 1 | 1 selects one-cycle latency; taken while `ce_n` is high |
| adv_n | input | 1 | Active-low address strobe |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable (read burst) |
| we_n | input | 1 | Active-low write enable (write burst) |
| dq_i | input | DW | Value received from the shared bus |
| dq_o | output | DW | Read data to the shared bus |
| dq_oe | output | 1 | Drive enable for `dq_o` |
| rdy | output | 1 | Burst pacing handshake to the host |
| addr | output | ADDR_W | Latched address |
| src_valid | input | 1 | Read-data stream: word offered |
| src_ready | output | 1 | Read-data stream: word accepted |
| src_data | input | DW | Read-data stream word |
| snk_valid | output | 1 | Write-data stream: word offered |
| snk_ready | input | 1 | Write-data stream: word accepted |
| snk_data | output | DW | Write-data stream word |

## Verification
Two pairs of events can land on the same edge. In the first, a buffer refill happens on the edge where a burst is waiting to start, while RDY is being held back. In the second, the read buffer is being popped to discard an aborted burst on the edge where the stream pushes a new word into it. The bench starts an enable against an empty read buffer, or a full write buffer, and feeds or drains that buffer a few cycles later. It requires RDY to stay low until the buffer can cover a whole burst, and then requires an unbroken burst. After an abort, it refills at once and checks through the scoreboard queue that the next burst begins exactly at the word after the discarded ones.

// File: rtl/admux_pkg.sv
package admux_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RWAIT, S_RBURST, S_RDROP, S_RHOLD,
    S_WWAIT, S_WBURST, S_WTAIL, S_WHOLD
  } seq_state_t;
endpackage

// File: rtl/admux_fifo.sv
module admux_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R10
endmodule

// File: rtl/admux_addr_latch.sv
module admux_addr_latch #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              lat_short_in,
  input  logic [ADDR_W-1:0] bus_lo,
  output logic [ADDR_W-1:0] addr,
  output logic              lat_short_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr        <= '0;
      lat_short_q <= 1'b0;
    end else begin
      if (!adv_n && !ce_n) addr <= bus_lo;
      if (ce_n) lat_short_q <= lat_short_in;
    end
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_n || ce_n) |=> $stable(addr)); // R1
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |=> $stable(lat_short_q)); // R6
endmodule

// File: rtl/admux_burst_seq.sv
module admux_burst_seq
  import admux_pkg::*;
#(
  parameter int DW    = 16,
  parameter int BURST = 4,
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ce_n,
  input  logic                        oe_n,
  input  logic                        we_n,
  input  logic                        lat_short,
  input  logic [DW-1:0]               dq_i,
  input  logic [DW-1:0]               rd_head,
  input  logic [$clog2(DEPTH+1)-1:0]  rd_cnt,
  input  logic [$clog2(DEPTH+1)-1:0]  wr_cnt,
  output logic                        rd_pop,
  output logic                        wr_push,
  output logic [DW-1:0]               wr_data,
  output logic                        rdy,
  output logic [DW-1:0]               dq_o,
  output logic                        dq_oe
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int BCW = $clog2(BURST + 1);
  localparam logic [BCW-1:0] LAST = BCW'(BURST);

  seq_state_t     state;
  logic [BCW-1:0] bcnt;
  logic           tail;
  logic           oe_act, we_act, rd_ok, wr_ok, rd_launch, wr_launch;

  assign oe_act = !ce_n && !oe_n;
  assign we_act = !ce_n && !we_n;
  assign rd_ok  = rd_cnt >= CW'(BURST);
  assign wr_ok  = (CW'(DEPTH) - wr_cnt) >= CW'(BURST);

  assign rd_launch = oe_act && rd_ok &&
                     ((state == S_IDLE && lat_short) || state == S_RWAIT);
  assign wr_launch = we_act && !oe_act && wr_ok &&
                     ((state == S_IDLE && lat_short) || state == S_WWAIT);

  assign rd_pop  = rd_launch ||
                   (state == S_RBURST && oe_act && bcnt < LAST) ||
                   (state == S_RDROP);
  assign wr_push = (state == S_WBURST) && we_act;
  assign wr_data = dq_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      bcnt  <= '0;
      tail  <= 1'b0;
      rdy   <= 1'b0;
      dq_o  <= '0;
      dq_oe <= 1'b0;
    end else begin
      if (rd_launch) begin
        state <= S_RBURST;
        rdy   <= 1'b1;
        dq_oe <= 1'b1;
        dq_o  <= rd_head;
        bcnt  <= BCW'(1);
      end else if (wr_launch) begin
        state <= S_WBURST;
        rdy   <= 1'b1;
        bcnt  <= '0;
      end else begin
        case (state)
          S_IDLE: begin
            if (oe_act)      state <= S_RWAIT;
            else if (we_act) state <= S_WWAIT;
          end
          S_RWAIT: if (!oe_act) state <= S_IDLE;
          S_RBURST: begin
            if (!oe_act) begin
              rdy   <= 1'b0;
              dq_oe <= 1'b0;
              state <= (bcnt < LAST) ? S_RDROP : S_IDLE;
            end else if (bcnt < LAST) begin
              dq_o <= rd_head;
              bcnt <= bcnt + 1'b1;
            end else begin
              rdy   <= 1'b0;
              state <= S_RHOLD;
            end
          end
          S_RDROP: begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == LAST - 1'b1) state <= S_IDLE;
          end
          S_RHOLD: begin
            if (!oe_act) begin
              dq_oe <= 1'b0;
              state <= S_IDLE;
            end
          end
          S_WWAIT: if (!we_act) state <= S_IDLE;
          S_WBURST: begin
            if (!we_act) begin
              rdy   <= 1'b0;
              state <= S_IDLE;
            end else begin
              bcnt <= bcnt + 1'b1;
              if (bcnt == LAST - 1'b1) begin
                state <= S_WTAIL;
                tail  <= 1'b0;
              end
            end
          end
          S_WTAIL: begin
            if (!tail) tail <= 1'b1;
            else begin
              rdy   <= 1'b0;
              state <= S_WHOLD;
            end
          end
          S_WHOLD: if (!we_act) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> rd_cnt != '0); // R7
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_push |-> wr_cnt < CW'(DEPTH)); // R7
  AST_RDY_NO_MIDBURST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RBURST && oe_act && bcnt < LAST) |=> rdy); // R7
  AST_BUS_QUIET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WBURST || state == S_WTAIL) |-> !dq_oe); // R3
  AST_TAIL_KEEPS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WTAIL) |-> rdy); // R5
endmodule

// File: rtl/admux_burst_slave.sv
module admux_burst_slave #(
  parameter int DW     = 16,
  parameter int ADDR_W = 8,
  parameter int BURST  = 4,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_short,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DW-1:0]     dq_i,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe,
  output logic              rdy,
  output logic [ADDR_W-1:0] addr,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DW-1:0]     src_data,
  output logic              snk_valid,
  input  logic              snk_ready,
  output logic [DW-1:0]     snk_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          lat_q, rd_pop, wr_push, rd_full, rd_empty, wr_full, wr_empty;
  logic [DW-1:0] rd_head, wr_data;
  logic [CW-1:0] rd_cnt, wr_cnt;

  admux_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .adv_n(adv_n), .ce_n(ce_n),
    .lat_short_in(lat_short), .bus_lo(dq_i[ADDR_W-1:0]),
    .addr(addr), .lat_short_q(lat_q)
  );

  admux_fifo #(.W(DW), .DEPTH(DEPTH)) u_rd_buf (
    .clk(clk), .rst_n(rst_n), .push(src_valid), .push_data(src_data),
    .pop(rd_pop), .head(rd_head), .count(rd_cnt),
    .full(rd_full), .empty(rd_empty)
  );

  admux_fifo #(.W(DW), .DEPTH(DEPTH)) u_wr_buf (
    .clk(clk), .rst_n(rst_n), .push(wr_push), .push_data(wr_data),
    .pop(snk_ready), .head(snk_data), .count(wr_cnt),
    .full(wr_full), .empty(wr_empty)
  );

  admux_burst_seq #(.DW(DW), .BURST(BURST), .DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .lat_short(lat_q), .dq_i(dq_i), .rd_head(rd_head), .rd_cnt(rd_cnt),
    .wr_cnt(wr_cnt), .rd_pop(rd_pop), .wr_push(wr_push), .wr_data(wr_data),
    .rdy(rdy), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  assign src_ready = !rd_full;
  assign snk_valid = !wr_empty;

  AST_NO_READ_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> !rd_empty); // R8
  AST_NO_WRITE_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_push |-> !wr_full); // R7
endmodule

// File: tb/test_admux_burst_slave.sv
module test_admux_burst_slave;
  localparam int DW = 16, AWD = 8, B = 4, D = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lat_short = 1'b0, adv_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [DW-1:0] dq_i = '0, src_data = '0;
  logic src_valid = 1'b0, snk_ready = 1'b1;
  logic [DW-1:0] dq_o, snk_data;
  logic dq_oe, rdy, src_ready, snk_valid;
  logic [AWD-1:0] addr;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] rd_exp[$];
  logic [DW-1:0] wr_exp[$];

  always #5 clk = ~clk;

  admux_burst_slave #(.DW(DW), .ADDR_W(AWD), .BURST(B), .DEPTH(D)) i_admux_burst_slave (
    .clk(clk), .rst_n(rst_n), .lat_short(lat_short), .adv_n(adv_n), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .rdy(rdy),
    .addr(addr), .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor on the write-sink stream
  always @(posedge clk) begin
    if (rst_n && snk_valid && snk_ready) begin
      if (wr_exp.size() == 0) check(1'b0, "R9 unexpected sink word", snk_data, '0);
      else begin
        logic [DW-1:0] e;
        e = wr_exp.pop_front();
        check(snk_data == e, "R4 R10 sink word", snk_data, e);
      end
    end
  end

  // Driver: feed read buffer, recording expected read beats
  task automatic feed(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!src_ready) @(negedge clk);
      src_valid = 1'b1;
      src_data  = base + DW'(i);
      rd_exp.push_back(base + DW'(i));
      @(negedge clk);
      src_valid = 1'b0;
    end
  endtask

  task automatic do_read(input int lat, input int keep, input bit timed);
    int k;
    logic [DW-1:0] e;
    @(negedge clk);
    oe_n = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (!rdy && k < 100);
    if (timed) check(k == lat, "R2 R6 read latency", k, lat);
    for (int i = 0; i < keep; i++) begin
      if (i > 0) @(negedge clk);
      e = rd_exp.pop_front();
      check(dq_oe && rdy && dq_o == e, "R3 R7 read beat", {dq_oe, rdy, dq_o}, {2'b11, e});
    end
    if (keep == B) begin
      @(negedge clk);
      check(!rdy && dq_oe && dq_o == e, "R3 rdy drop after last beat", {rdy, dq_oe, dq_o}, {2'b01, e});
      @(negedge clk);
      check(dq_oe && dq_o == e, "R3 last beat held", {dq_oe, dq_o}, {1'b1, e});
      oe_n = 1'b1;
      @(negedge clk);
      check(!dq_oe, "R3 bus released", dq_oe, 0);
    end else begin
      oe_n = 1'b1;
      for (int i = keep; i < B; i++) void'(rd_exp.pop_front());
      @(negedge clk);
      check(!rdy && !dq_oe, "R8 abort read", {rdy, dq_oe}, 0);
    end
  endtask

  task automatic do_write(input int lat, input int keep, input bit timed,
                          input logic [DW-1:0] base);
    int k, n;
    @(negedge clk);
    we_n = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (!rdy && k < 100);
    if (timed) check(k == lat, "R4 R6 write latency", k, lat);
    for (int i = 0; i < keep; i++) begin
      check(rdy, "R7 rdy high in write burst", rdy, 1);
      dq_i = base + DW'(i);
      wr_exp.push_back(base + DW'(i));
      @(negedge clk);
    end
    if (keep == B) begin
      n = 1;
      while (rdy && n < 10) begin @(negedge clk); n++; end
      check(n == 3, "R5 write rdy tail", n, 3);
    end else begin
      dq_i = 16'hDEAD;
    end
    we_n = 1'b1;
    @(negedge clk);
    check(!rdy, "R9 R5 rdy low after write", rdy, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rdy && !dq_oe && !snk_valid && addr == '0, "R11 reset state",
          {rdy, dq_oe, snk_valid, addr}, 0);

    // R1 address phase
    ce_n = 1'b0; adv_n = 1'b0; dq_i = 16'hA35A;
    @(negedge clk);
    adv_n = 1'b1; dq_i = 16'h0077;
    @(negedge clk);
    check(addr == 8'h5A, "R1 address latched", addr, 8'h5A);
    @(negedge clk);
    check(addr == 8'h5A, "R1 address held without strobe", addr, 8'h5A);

    // R10 fill read buffer to full
    feed(8, 16'h1000);
    check(!src_ready, "R10 src_ready low when full", src_ready, 0);

    do_read(2, B, 1);          // R2 R3
    do_read(2, 2, 1);          // R8 abort after two beats
    feed(4, 16'h2000);
    do_read(2, B, 1);          // R8 next burst starts after discarded words

    do_write(2, B, 1, 16'h3000);   // R4 R5
    do_write(2, 2, 1, 16'h3100);   // R9
    repeat (6) @(negedge clk);
    check(wr_exp.size() == 0, "R9 R10 sink drained", wr_exp.size(), 0);

    // R6 setting ignored while selected, taken while deselected
    lat_short = 1'b1;
    feed(4, 16'h4000);
    do_read(2, B, 1);
    ce_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0;
    feed(4, 16'h4100);
    do_read(1, B, 1);
    do_write(1, B, 1, 16'h5000);

    // R7 read hold-off on empty buffer
    fork
      do_read(1, B, 0);
      begin
        repeat (5) begin
          @(negedge clk);
          check(!rdy, "R7 read held off while empty", rdy, 0);
        end
        feed(4, 16'h6000);
      end
    join

    // R7 write hold-off on full buffer
    snk_ready = 1'b0;
    do_write(1, B, 0, 16'h7000);
    do_write(1, B, 0, 16'h7100);
    fork
      do_write(1, B, 0, 16'h7200);
      begin
        repeat (5) begin
          @(negedge clk);
          check(!rdy, "R7 write held off while full", rdy, 0);
        end
        snk_ready = 1'b1;
      end
    join
    repeat (20) @(negedge clk);
    check(wr_exp.size() == 0, "R10 all sink words delivered", wr_exp.size(), 0);
    check(rd_exp.size() == 0, "R3 all read words consumed", rd_exp.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule